// File: doc/BRIEF.md
# Cartridge ROM Bank Controller with Nibble RAM

This block sits on a cartridge and watches a reduced console address bus. The bus carries only the two top address bits and the low nine bits. It decodes strobed writes into two control registers. One is a RAM gate, which opens the internal memory only when it holds a particular code. The other is a 4-bit ROM bank number. From these registers and the live address the block drives the upper ROM address lines and a low-active ROM select. It also holds a 512-entry, 4-bit-wide memory that the host reads and writes over a 4-bit data bus while the gate is open.

The console strobes are sampled on the block clock. A three-state write sequencer tracks the write strobe and has these states:
- ST_IDLE: no write in progress.
- ST_STROBE: the write strobe is held low. Address, data and chip select are captured on every cycle of this state.
- ST_COMMIT: a single cycle that applies the captured write.

The sequencer moves between them as follows:
- ST_IDLE goes to ST_STROBE when the write strobe is low.
- ST_STROBE stays in ST_STROBE while the strobe stays low.
- ST_STROBE goes to ST_COMMIT when the strobe is seen high.
- ST_COMMIT returns to ST_STROBE if a new strobe is already low. Otherwise it returns to ST_IDLE.

The bidirectional data bus is split into an input, an output and an output enable. The output reads zero whenever the enable is low.

Top module: `nibble_bank_ctrl`

## Requirements
- R1: Asynchronous low reset clears the RAM gate and the bank register. After reset, the RAM is closed and the upper window (A14=1) shows bank 1.
- R2: A write with A15..A14=00 and A8=0 loads the RAM gate from D3..D0. Only the value 4'hA opens the RAM. Any other value closes it.
- R3: A write with A15..A14=00 and A8=1 loads the 4-bit bank register from D3..D0. No chip select is needed for either register.
- R4: While A14=1, rom_bank shows the bank register, except that a stored 0 is shown as 1.
- R5: While A14=0, rom_bank is 0.
- R6: rom_cs_n is low exactly when rd_n is low and A15=0.
- R7: The RAM window is A15..A14=10 with cs_n low. A8..A0 form the word address into 512 nibbles. With the RAM open and rd_n low, data_oe is 1 and data_out returns the last nibble written to that address.
- R8: A write takes effect on the second clock edge after wr_n is first sampled high. It uses the address and data that were sampled last while wr_n was low. Nothing changes while wr_n stays low.
- R9: While the RAM is closed, writes to the RAM window leave the memory unchanged, and reads keep data_oe at 0.
- R10: Reset does not alter the RAM contents.
- R11: A RAM-window write with cs_n high has no effect.
- R12: Writes with A15..A14 of 01 or 11 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the strobes |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cs_n | input | 1 | Chip select for the RAM window, active low |
| addr_hi | input | 2 | Address bits A15..A14 |
| addr_lo | input | 9 | Address bits A8..A0 |
| data_in | input | 4 | Data bus, inbound half |
| data_out | output | 4 | Data bus, outbound half |
| data_oe | output | 1 | Enable for the outbound data bus |
| rom_bank | output | 4 | Upper ROM address lines RA17..RA14 |
| rom_cs_n | output | 1 | ROM select, active low |

## Verification
The hardest case to reach is a RAM write attempted while the gate is closed, because a write that did nothing is invisible at the ports. To expose it, the stimulus first opens the gate and stores a known nibble. It then closes the gate with a non-magic value and writes a different nibble to the same address. Finally it reopens the gate and reads the address back. A second hard case is a write strobe held low for many cycles: the bank output is checked in the middle of the hold and again after release.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
    localparam int HI_W    = 2;
    localparam int DATA_W  = 4;
    localparam int RAM_AW  = 9;
    localparam logic [HI_W-1:0]   REG_WIN  = 2'b00;
    localparam logic [HI_W-1:0]   RAM_WIN  = 2'b10;
    localparam logic [DATA_W-1:0] GATE_KEY = 4'hA;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_COMMIT
    } wr_state_e;
endpackage

// File: rtl/nbc_strobe_fsm.sv
module nbc_strobe_fsm
    import nbc_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          cs_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          commit,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_data,
    output logic          c_cs_n
);
    wr_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (!wr_n) state_nx = ST_STROBE;
            ST_STROBE: if (wr_n)  state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = wr_n ? ST_IDLE : ST_STROBE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb commit = (state == ST_COMMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_addr <= '0;
            c_data <= '0;
            c_cs_n <= 1'b1;
        end else if (!wr_n) begin
            c_addr <= addr;
            c_data <= din;
            c_cs_n <= cs_n;
        end
    end

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);  // R8
    AST_COMMIT_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(state == ST_STROBE) && $past(wr_n));  // R8
endmodule

// File: rtl/nbc_regs.sv
module nbc_regs
    import nbc_pkg::*;
#(
    parameter int HW = 2,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [HW-1:0] c_hi,
    input  logic          c_sel,
    input  logic [DW-1:0] c_data,
    output logic          ram_on,
    output logic [DW-1:0] bank_q
);
    logic [DW-1:0] gate_q;
    logic          hit;

    always_comb hit = commit && (c_hi == REG_WIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
            bank_q <= '0;
        end else if (hit) begin
            if (c_sel) bank_q <= c_data;
            else       gate_q <= c_data;
        end
    end

    always_comb ram_on = (gate_q == GATE_KEY);

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && c_hi == REG_WIN && c_sel) |=> bank_q == $past(c_data));  // R3
    AST_GATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && c_hi == REG_WIN && !c_sel) |=> ram_on == ($past(c_data) == GATE_KEY));  // R2
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && c_hi == REG_WIN) |=> $stable(bank_q));  // R12
endmodule

// File: rtl/nbc_nibble_ram.sv
module nbc_nibble_ram #(
    parameter int AW = 9,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb rdata = mem[raddr];
endmodule

// File: rtl/nibble_bank_ctrl.sv
module nibble_bank_ctrl
    import nbc_pkg::*;
#(
    parameter int AH_W = HI_W,
    parameter int AL_W = RAM_AW,
    parameter int DW   = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            cs_n,
    input  logic [AH_W-1:0] addr_hi,
    input  logic [AL_W-1:0] addr_lo,
    input  logic [DW-1:0]   data_in,
    output logic [DW-1:0]   data_out,
    output logic            data_oe,
    output logic [DW-1:0]   rom_bank,
    output logic            rom_cs_n
);
    localparam int AW  = AH_W + AL_W;
    localparam int SEL = AL_W - 1;

    logic            commit, c_cs_n, ram_on, ram_we;
    logic [AW-1:0]   c_addr;
    logic [DW-1:0]   c_data, bank_q, rdata;

    nbc_strobe_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_n(cs_n),
        .addr({addr_hi, addr_lo}), .din(data_in),
        .commit(commit), .c_addr(c_addr), .c_data(c_data), .c_cs_n(c_cs_n)
    );

    nbc_regs #(.HW(AH_W), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .c_hi(c_addr[AW-1:AL_W]), .c_sel(c_addr[SEL]), .c_data(c_data),
        .ram_on(ram_on), .bank_q(bank_q)
    );

    always_comb ram_we = commit && !c_cs_n && ram_on &&
                         (c_addr[AW-1:AL_W] == RAM_WIN);

    nbc_nibble_ram #(.AW(AL_W), .DW(DW)) u_ram (
        .clk(clk), .we(ram_we), .waddr(c_addr[AL_W-1:0]), .wdata(c_data),
        .raddr(addr_lo), .rdata(rdata)
    );

    always_comb begin
        data_oe  = !rd_n && !cs_n && ram_on && (addr_hi == RAM_WIN);
        data_out = data_oe ? rdata : '0;
        rom_cs_n = !(!rd_n && !addr_hi[AH_W-1]);
        if (!addr_hi[0])       rom_bank = '0;
        else if (bank_q == '0) rom_bank = DW'(1);
        else                   rom_bank = bank_q;
    end

    AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> ram_on && !rd_n && !cs_n);  // R9
    AST_UPPER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hi[0] |-> rom_bank != '0);  // R4
    AST_LOWER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hi[0] |-> rom_bank == '0);  // R5
    AST_ROMCS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs_n |-> !rd_n && !addr_hi[AH_W-1]);  // R6
endmodule

// File: tb/tb_nibble_bank_ctrl.sv
module tb_nibble_bank_ctrl;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       rd_n = 1'b1, wr_n = 1'b1, cs_n = 1'b1;
    logic [1:0] addr_hi = '0;
    logic [8:0] addr_lo = '0;
    logic [3:0] data_in = '0, data_out, rom_bank;
    logic       data_oe, rom_cs_n;
    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [3:0] bank;
        logic       romcs;
        logic       oe;
        logic [3:0] dat;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    nibble_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n),
        .addr_hi(addr_hi), .addr_lo(addr_lo), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .rom_bank(rom_bank),
        .rom_cs_n(rom_cs_n)
    );

    initial begin : monitor
        forever begin
            exp_t e;
            wait (q.size() != 0);
            #1;
            e = q.pop_front();
            checks++;
            if (rom_bank !== e.bank || rom_cs_n !== e.romcs || data_oe !== e.oe ||
                (e.oe && data_out !== e.dat)) begin
                errors++;
                $display("FAIL %s: bank=%h romcs_n=%b oe=%b data=%h expected bank=%h romcs_n=%b oe=%b data=%h",
                         e.tag, rom_bank, rom_cs_n, data_oe, data_out,
                         e.bank, e.romcs, e.oe, e.dat);
            end
        end
    end

    task automatic bus_write(input logic [1:0] hi, input logic [8:0] lo,
                             input logic [3:0] d, input logic cs);
        @(negedge clk);
        addr_hi = hi; addr_lo = lo; data_in = d; cs_n = cs; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic look(input logic [1:0] hi, input logic [8:0] lo, input logic rd,
                        input logic cs, input logic [3:0] eb, input logic ec,
                        input logic eo, input logic [3:0] ed, input string tag);
        exp_t e;
        @(negedge clk);
        addr_hi = hi; addr_lo = lo; rd_n = rd; cs_n = cs;
        #2;
        e.tag = tag; e.bank = eb; e.romcs = ec; e.oe = eo; e.dat = ed;
        q.push_back(e);
        wait (q.size() == 0);
        #1;
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (2) @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        look(2'b01, 9'h000, 1, 1, 4'h1, 1, 0, 4'h0, "R1 bank after reset");
        look(2'b10, 9'h005, 0, 0, 4'h0, 1, 0, 4'h0, "R1 ram closed after reset");
        // R3 R4 R6 R5: bank mapping
        bus_write(2'b00, 9'h100, 4'h5, 1);
        look(2'b01, 9'h000, 0, 1, 4'h5, 0, 0, 4'h0, "R3 R6 bank 5 upper read");
        look(2'b00, 9'h000, 0, 1, 4'h0, 0, 0, 4'h0, "R5 lower window bank 0");
        look(2'b11, 9'h000, 0, 1, 4'h5, 1, 0, 4'h0, "R6 romcs high A15=1");
        bus_write(2'b00, 9'h1FF, 4'h0, 1);
        look(2'b01, 9'h0AA, 1, 1, 4'h1, 1, 0, 4'h0, "R4 bank 0 shown as 1");
        bus_write(2'b00, 9'h100, 4'hF, 1);
        look(2'b01, 9'h000, 1, 1, 4'hF, 1, 0, 4'h0, "R4 bank F");
        // R8: long strobe
        @(negedge clk);
        addr_hi = 2'b00; addr_lo = 9'h100; data_in = 4'h3; wr_n = 1'b0;
        repeat (8) @(negedge clk);
        look(2'b00, 9'h100, 1, 1, 4'h0, 1, 0, 4'h0, "R8 lower during hold");
        addr_hi = 2'b00; addr_lo = 9'h100;
        look(2'b01, 9'h100, 1, 1, 4'hF, 1, 0, 4'h0, "R8 no change while wr low");
        addr_hi = 2'b00; addr_lo = 9'h100;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); addr_hi = 2'b01;
        #2; checks++;
        if (rom_bank !== 4'hF) begin errors++;
            $display("FAIL R8 early commit: bank=%h expected %h", rom_bank, 4'hF); end
        look(2'b01, 9'h000, 1, 1, 4'h3, 1, 0, 4'h0, "R8 applied after release");
        // R2 R7: open RAM, write and read
        bus_write(2'b00, 9'h000, 4'hA, 1);
        bus_write(2'b10, 9'h005, 4'h3, 0);
        bus_write(2'b10, 9'h000, 4'h1, 0);
        bus_write(2'b10, 9'h1FF, 4'hE, 0);
        bus_write(2'b10, 9'h100, 4'h9, 0);
        look(2'b10, 9'h000, 0, 0, 4'h0, 1, 1, 4'h1, "R7 read addr 000");
        look(2'b10, 9'h1FF, 0, 0, 4'h0, 1, 1, 4'hE, "R7 read addr 1FF");
        look(2'b10, 9'h100, 0, 0, 4'h0, 1, 1, 4'h9, "R7 read addr 100");
        look(2'b10, 9'h005, 0, 0, 4'h0, 1, 1, 4'h3, "R7 read addr 005");
        look(2'b10, 9'h000, 0, 1, 4'h0, 1, 0, 4'h0, "R7 no drive with cs high");
        // R11
        bus_write(2'b10, 9'h000, 4'h6, 1);
        look(2'b10, 9'h000, 0, 0, 4'h0, 1, 1, 4'h1, "R11 cs high write ignored");
        // R12
        bus_write(2'b01, 9'h000, 4'h7, 1);
        bus_write(2'b11, 9'h100, 4'h2, 1);
        look(2'b01, 9'h000, 1, 1, 4'h3, 1, 0, 4'h0, "R12 bank unchanged");
        look(2'b10, 9'h000, 0, 0, 4'h0, 1, 1, 4'h1, "R12 gate unchanged");
        // R9: closed RAM
        bus_write(2'b00, 9'h000, 4'h5, 1);
        bus_write(2'b10, 9'h005, 4'h7, 0);
        look(2'b10, 9'h005, 0, 0, 4'h0, 1, 0, 4'h0, "R9 read while closed");
        bus_write(2'b00, 9'h000, 4'hA, 1);
        look(2'b10, 9'h005, 0, 0, 4'h0, 1, 1, 4'h3, "R9 closed write ignored");
        // R2: non-key value
        bus_write(2'b00, 9'h000, 4'hB, 1);
        look(2'b10, 9'h005, 0, 0, 4'h0, 1, 0, 4'h0, "R2 value B closes");
        // R10 R1: reset keeps RAM
        pulse_reset();
        look(2'b01, 9'h000, 1, 1, 4'h1, 1, 0, 4'h0, "R1 bank cleared by reset");
        look(2'b10, 9'h1FF, 0, 0, 4'h0, 1, 0, 4'h0, "R1 gate cleared by reset");
        bus_write(2'b00, 9'h000, 4'hA, 1);
        look(2'b10, 9'h1FF, 0, 0, 4'h0, 1, 1, 4'hE, "R10 contents survive reset");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule